// File: doc/BRIEF.md
# Bus Ownership Arbiter With Grant Acknowledge

This block decides when the default processor master hands the shared bus to one of several alternate masters, such as DMA engines, and when it takes the bus back. The alternate masters each drive an active-low request. All requests are combined into one shared request line, which is modelled as the AND of the active-low inputs. The arbiter waits until the processor's current bus cycle has finished. It then drives an individual active-low grant to the single requester it has chosen by fixed priority.

Once the chosen master asserts its active-low grant acknowledge, the grant is dropped. The acknowledge alone keeps that master in control. The requesters' lines no longer matter until the acknowledge goes away. When the acknowledge is released, the bus returns to the processor unless another request is waiting. If a request is waiting, it is granted directly. If the chosen requester gives up before it acknowledges, the grant is withdrawn.

Top module: `bus_handover_arb`

## Requirements
- R1: After reset, and at any clock edge sampled with rstN low, every grantN bit is 1 and cpuOwnsBus is 1.
- R2: busReqN is 0 whenever any bit of reqN is 0, and 1 when all bits of reqN are 1, in the same cycle.
- R3: While the processor owns the bus (cpuOwnsBus = 1), a clock edge that samples a pending request with cycActN = 1 asserts a grant after that edge and clears cpuOwnsBus.
- R4: While the processor owns the bus and cycActN = 0 (a cycle in progress), no grant is asserted. The grant appears after the first edge that samples cycActN = 1 with the request still pending.
- R5: Requests sampled in the same cycle are resolved by fixed priority: bit i of reqN belongs to requester i, and the lowest index wins. Its grant is bit i of grantN.
- R6: At most one bit of grantN is 0 at any time.
- R7: If the granted requester negates its request before any acknowledge is asserted, the grant is removed at the next edge and cpuOwnsBus returns to 1. This holds even if another request is pending.
- R8: An acknowledge (any ackN bit 0) sampled while a grant is asserted negates the grant at that edge, with cpuOwnsBus = 0. While the acknowledge stays asserted, no grant is issued, whatever the requests do.
- R9: When the acknowledge is negated and no request is pending, cpuOwnsBus becomes 1 after that edge and no grant is asserted.
- R10: When the acknowledge is negated while a request is pending, the highest-priority pending requester is granted after that edge, and cpuOwnsBus stays 0.
- R11: While a grant is asserted, a newly arriving request of higher priority does not move the grant to another requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqN | input | NUM_REQ | Per-requester bus request, active low |
| ackN | input | NUM_REQ | Per-requester grant acknowledge, active low |
| cycActN | input | 1 | Address strobe of the current master, active low (bus cycle in progress) |
| busReqN | output | 1 | Combined shared request line, active low |
| grantN | output | NUM_REQ | Per-requester bus grant, active low |
| cpuOwnsBus | output | 1 | High while the processor may run bus cycles |

## Verification
Several rules are checked as properties on every cycle:
- at most one grant at a time;
- no grant begins while the processor's cycle strobe is low;
- a pending request with the strobe high produces a grant on the next edge;
- an acknowledge removes the grant;
- a granted line never moves to another requester;
- a withdrawn request returns the bus to the processor;
- release with nothing pending restores processor ownership.

Only the bench's scenarios can show which requester actually wins a given mix of requests. The same holds for the direct re-grant on release with a request waiting, the locked winner with a higher-priority late arrival, and the effect of a reset taken in the middle of a grant.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_GRANT = 2'd2,
    ARB_HELD  = 2'd3
  } arbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWinner;  // capture priority winner into grant register
    logic clearGrant;  // drop any grant
  } arbStrobe_t;

endpackage

// File: rtl/bus_handover_dp.sv
module bus_handover_dp
  import bus_handover_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic [NUM_REQ-1:0] ackN,
  input  arbStrobe_t         strobe,
  output logic               anyReq,
  output logic               ackSeen,
  output logic               winnerLive,
  output logic               busReqN,
  output logic [NUM_REQ-1:0] grantN
);

  logic [NUM_REQ-1:0] reqAct;
  logic [NUM_REQ-1:0] pickVec;
  logic [NUM_REQ-1:0] grantVec;
  logic [NUM_REQ:0]   seenBelow;

  assign reqAct       = ~reqN;
  assign seenBelow[0] = 1'b0;

  // Fixed priority: lowest index wins, ripple of "someone below asked"
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_pick
    assign pickVec[g]     = reqAct[g] & ~seenBelow[g];
    assign seenBelow[g+1] = seenBelow[g] | reqAct[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec <= '0;
    end else if (strobe.loadWinner) begin
      grantVec <= pickVec;
    end else if (strobe.clearGrant) begin
      grantVec <= '0;
    end
  end

  assign anyReq     = seenBelow[NUM_REQ];
  assign ackSeen    = ~(&ackN);
  assign winnerLive = |(grantVec & reqAct);
  assign busReqN    = ~anyReq;
  assign grantN     = ~grantVec;

endmodule

// File: rtl/bus_handover_ctl.sv
module bus_handover_ctl
  import bus_handover_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ackSeen,
  input  logic       winnerLive,
  input  logic       cycActN,
  output arbStrobe_t strobe,
  output logic       cpuOwnsBus
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    unique case (state)
      ARB_IDLE, ARB_WAIT: begin
        if (!anyReq) begin
          stateNext = ARB_IDLE;
        end else if (cycActN) begin
          stateNext         = ARB_GRANT;
          strobe.loadWinner = 1'b1;
        end else begin
          stateNext = ARB_WAIT;
        end
      end
      ARB_GRANT: begin
        if (ackSeen) begin
          stateNext         = ARB_HELD;
          strobe.clearGrant = 1'b1;
        end else if (!winnerLive) begin
          stateNext         = ARB_IDLE;
          strobe.clearGrant = 1'b1;
        end
      end
      ARB_HELD: begin
        if (!ackSeen) begin
          if (anyReq) begin
            stateNext         = ARB_GRANT;
            strobe.loadWinner = 1'b1;
          end else begin
            stateNext = ARB_IDLE;
          end
        end
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ARB_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign cpuOwnsBus = (state == ARB_IDLE) || (state == ARB_WAIT);

endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb
  import bus_handover_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic [NUM_REQ-1:0] ackN,
  input  logic               cycActN,
  output logic               busReqN,
  output logic [NUM_REQ-1:0] grantN,
  output logic               cpuOwnsBus
);

  arbStrobe_t strobe;
  logic       anyReq;
  logic       ackSeen;
  logic       winnerLive;

  bus_handover_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .anyReq     (anyReq),
    .ackSeen    (ackSeen),
    .winnerLive (winnerLive),
    .cycActN    (cycActN),
    .strobe     (strobe),
    .cpuOwnsBus (cpuOwnsBus)
  );

  bus_handover_dp #(.NUM_REQ(NUM_REQ)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqN       (reqN),
    .ackN       (ackN),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .ackSeen    (ackSeen),
    .winnerLive (winnerLive),
    .busReqN    (busReqN),
    .grantN     (grantN)
  );

endmodule

// File: rtl/bus_handover_chk.sv
module bus_handover_chk #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqN,
  input logic [NUM_REQ-1:0] ackN,
  input logic               cycActN,
  input logic [NUM_REQ-1:0] grantN,
  input logic               cpuOwnsBus
);

  // R6: never more than one grant
  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~grantN));

  // R4: processor cycle in progress blocks a new grant
  p_no_grant_in_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOwnsBus && !cycActN && (&grantN)) |=> (&grantN));

  // R3: pending request with strobe high yields grant next edge
  p_grant_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOwnsBus && cycActN && !(&reqN)) |=> (!(&grantN) && !cpuOwnsBus));

  // R8: acknowledge removes the grant, alternate master holds
  p_ack_drops_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!(&grantN) && !(&ackN)) |=> ((&grantN) && !cpuOwnsBus));

  // R11: an asserted grant never jumps to another requester
  p_grant_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(&grantN) |=> ((&grantN) || $stable(grantN)));

  // R7: granted requester withdraws before acknowledge
  p_withdraw_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(&grantN) && (&ackN) && ((~grantN & ~reqN) == '0)) |=> ((&grantN) && cpuOwnsBus));

  // R9: release with nothing pending returns bus to processor
  p_release_cpu_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuOwnsBus && (&grantN) && (&ackN) && (&reqN)) |=> (cpuOwnsBus && (&grantN)));

endmodule

bind bus_handover_arb bus_handover_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqN       (reqN),
  .ackN       (ackN),
  .cycActN    (cycActN),
  .grantN     (grantN),
  .cpuOwnsBus (cpuOwnsBus)
);

// File: tb/bus_handover_arb_bench.sv
module bus_handover_arb_bench;

  localparam int NREQ = 4;

  typedef struct packed {
    logic [3:0] reqN;
    logic [3:0] ackN;
    logic       cycN;
    logic [3:0] expGrantN;
    logic       expCpu;
    logic [7:0] reqTag;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'b1111, 4'b1111, 1'b1, 4'b1111, 1'b1, 8'd1},  // R1 idle after reset
    '{4'b1011, 4'b1111, 1'b0, 4'b1111, 1'b1, 8'd4},  // R4 cycle running
    '{4'b1011, 4'b1111, 1'b0, 4'b1111, 1'b1, 8'd4},  // R4 still running
    '{4'b1011, 4'b1111, 1'b1, 4'b1011, 1'b0, 8'd4},  // R4 cycle ended
    '{4'b1001, 4'b1111, 1'b1, 4'b1011, 1'b0, 8'd11}, // R11 req1 arrives late
    '{4'b1001, 4'b1011, 1'b1, 4'b1111, 1'b0, 8'd8},  // R8 req2 acks
    '{4'b1101, 4'b1011, 1'b1, 4'b1111, 1'b0, 8'd8},  // R8 held despite req1
    '{4'b1101, 4'b1111, 1'b0, 4'b1101, 1'b0, 8'd10}, // R10 direct regrant
    '{4'b1111, 4'b1101, 1'b1, 4'b1111, 1'b0, 8'd8},  // R8 req1 acks
    '{4'b1111, 4'b1111, 1'b1, 4'b1111, 1'b1, 8'd9},  // R9 back to processor
    '{4'b0110, 4'b1111, 1'b1, 4'b1110, 1'b0, 8'd5},  // R5 req0 beats req3
    '{4'b0111, 4'b1111, 1'b1, 4'b1111, 1'b1, 8'd7},  // R7 req0 withdraws
    '{4'b0111, 4'b1111, 1'b1, 4'b0111, 1'b0, 8'd3},  // R3 req3 granted
    '{4'b0111, 4'b0111, 1'b1, 4'b1111, 1'b0, 8'd8},  // R8 req3 acks
    '{4'b1111, 4'b1111, 1'b1, 4'b1111, 1'b1, 8'd9}   // R9 release
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NREQ-1:0] reqN = '1;
  logic [NREQ-1:0] ackN = '1;
  logic            cycActN = 1'b1;
  logic            busReqN;
  logic [NREQ-1:0] grantN;
  logic            cpuOwnsBus;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_handover_arb #(.NUM_REQ(NREQ)) u_bus_handover_arb (
    .clk        (clk),
    .rstN       (rstN),
    .reqN       (reqN),
    .ackN       (ackN),
    .cycActN    (cycActN),
    .busReqN    (busReqN),
    .grantN     (grantN),
    .cpuOwnsBus (cpuOwnsBus)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic stepTo(input logic [3:0] r, input logic [3:0] a, input logic c);
    @(negedge clk);
    reqN = r; ackN = a; cycActN = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grant in reset", {4'b0, grantN}, {4'b0, 4'b1111});
    chk("R1 cpu in reset", {7'b0, cpuOwnsBus}, 8'd1);
    @(negedge clk);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      stepTo(VECS[i].reqN, VECS[i].ackN, VECS[i].cycN);
      chk($sformatf("R%0d vec %0d grant", VECS[i].reqTag, i),
          {4'b0, grantN}, {4'b0, VECS[i].expGrantN});
      chk($sformatf("R%0d vec %0d cpu", VECS[i].reqTag, i),
          {7'b0, cpuOwnsBus}, {7'b0, VECS[i].expCpu});
      chk($sformatf("R2 vec %0d shared request", i),
          {7'b0, busReqN}, {7'b0, &VECS[i].reqN});
      chk($sformatf("R6 vec %0d single grant", i),
          8'($countones(~grantN) <= 1), 8'd1);
    end

    // R5: all four together, lowest index wins
    stepTo(4'b0000, 4'b1111, 1'b1);
    chk("R5 all requesting", {4'b0, grantN}, {4'b0, 4'b1110});

    // R1: reset taken in the middle of a grant
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 reset mid grant", {4'b0, grantN}, {4'b0, 4'b1111});
    chk("R1 reset mid grant cpu", {7'b0, cpuOwnsBus}, 8'd1);
    @(negedge clk);
    rstN = 1'b1;
    reqN = '1;

    // R4: long processor cycle
    for (int k = 0; k < 5; k++) begin
      stepTo(4'b1101, 4'b1111, 1'b0);
      chk("R4 long cycle holds grant off", {4'b0, grantN}, {4'b0, 4'b1111});
    end
    stepTo(4'b1101, 4'b1111, 1'b1);
    chk("R4 grant after long cycle", {4'b0, grantN}, {4'b0, 4'b1101});

    // R7: withdraw while another requester pends, then regrant
    stepTo(4'b0111, 4'b1111, 1'b1);
    chk("R7 withdraw with other pending", {4'b0, grantN}, {4'b0, 4'b1111});
    chk("R7 cpu back", {7'b0, cpuOwnsBus}, 8'd1);
    stepTo(4'b0111, 4'b1111, 1'b1);
    chk("R3 regrant after withdraw", {4'b0, grantN}, {4'b0, 4'b0111});

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule